// File: doc/BRIEF.md
# Redundant Table Majority Decoder

This block rebuilds a small lookup table of byte values from a byte image that is known to hold bit errors. Every stored value appears eight times, and every entry of the table also has a second group of eight copies stored bit-inverted. The block reads the image one byte per cycle through a synchronous RAM read port. It first votes out the mode count and the register count. It then votes out every entry of the table and streams the entries to a table write port.

A vote collects the eight copies of one value. Only the first half of the copies can win, and each of them is compared only with the copies stored after it. When the plain copies of an entry give no winner, the block votes on the inverted copies and writes the complement of the winner. When a vote fails beyond that, or a byte address falls outside the image, the run stops and raises an error pulse. A successful run ends with a done pulse.

Top module: `majority_table_decoder`

## Requirements
- R1: After reset `busy`, `tbl_we`, `done`, `err` and `rd_en` are low, and `nmodes`/`nregs` read 0.
- R2: A `start` pulse seen while idle begins a run whose first read is issued in the next cycle. Each vote issues its eight reads on consecutive cycles with `rd_en` high. Read data is taken one cycle after its request. The vote result is acted on two cycles after the last read, so a vote occupies ten cycles.
- R3: The mode count is voted from bytes 0..7 and the register count from bytes 8..15. Both are shown on `nmodes`/`nregs` once voted, and both are cleared to 0 when a run starts.
- R4: A vote takes as candidates only copies 0..3 in that order. A candidate wins if more than four of the copies after it equal it, and the first winner is taken. Six equal copies can therefore pass, while five equal copies always fail.
- R5: With S = nmodes*nregs, the plain copy k of entry index e = mode*nregs + reg is at byte 16 + 2k*S + e. Entries are produced in rising e, with the register index running fastest. Each entry is written with `tbl_we` high, `tbl_idx` = e and `tbl_data` = winner, in the cycle in which its vote is acted on.
- R6: If the plain vote of an entry fails, a second vote runs over the bytes at 16 + (2k+1)*S + e. Its winner is written bit-complemented.
- R7: If both votes of an entry fail, `err` pulses for one cycle, nothing is written for that entry, and the run ends.
- R8: If the vote for the mode count or for the register count fails, `err` pulses in its decision cycle and the run ends.
- R9: A read whose byte address is not below `img_len` is not issued. `err` pulses in that cycle instead, and the run ends.
- R10: If either count is zero, `done` pulses in the decision cycle of the register count vote, and no table write happens.
- R11: `done` pulses in the same cycle as the write of the last entry, and never together with `err`. A `start` seen while busy has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| img_len | input | AW+1 | Number of valid bytes in the image |
| rd_en | output | 1 | Image read request |
| rd_addr | output | AW | Image byte address |
| rd_data | input | 8 | Image byte, valid one cycle after the request |
| tbl_we | output | 1 | Table entry write strobe |
| tbl_idx | output | 16 | Entry index mode*nregs+reg |
| tbl_data | output | 8 | Recovered entry value |
| done | output | 1 | Run finished successfully (pulse) |
| err | output | 1 | Run aborted (pulse) |
| busy | output | 1 | Run in progress |
| nmodes | output | 8 | Voted mode count |
| nregs | output | 8 | Voted register count |

## Verification
The write of the final entry and the done pulse share one cycle. This holds whether that entry came from its plain copies or from the inverted fallback. The bench provokes both variants and compares `tbl_we`, `tbl_idx`, `tbl_data`, `done` and `err` on every cycle against a behavioural timeline computed from the image. A second overlap is a restart request that arrives while a run is in progress. The bench injects one in mid-run and expects the timeline to be unchanged.

// File: rtl/majority_table_decoder.sv
module majority_table_decoder #(
  parameter int AW    = 12,
  parameter int NCOPY = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW:0]   img_len,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          tbl_we,
  output logic [15:0]   tbl_idx,
  output logic [7:0]    tbl_data,
  output logic          done,
  output logic          err,
  output logic          busy,
  output logic [7:0]    nmodes,
  output logic [7:0]    nregs
);
  localparam int KW     = $clog2(NCOPY);
  localparam int NCAND  = NCOPY / 2;
  localparam int THRESH = NCOPY / 2;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DRAIN, ST_EVAL} st_t;
  typedef enum logic [1:0] {PH_MODES, PH_REGS, PH_PLAIN, PH_INV} ph_t;

  st_t            state;
  ph_t            phase;
  logic [KW-1:0]  k, kq;
  logic           vld_q;
  logic [15:0]    idx;
  logic [7:0]     nm_q, nr_q;
  logic [7:0]     cpy [NCOPY];
  logic [15:0]    sz;
  logic [31:0]    lin;
  logic           in_rng, eval, last, maj_ok;
  logic [7:0]     maj_val;

  function automatic logic [8:0] vote(input logic [7:0] c [NCOPY]);
    logic [8:0] r;
    int cnt;
    r = '0;
    for (int i = 0; i < NCAND; i++) begin
      cnt = 0;
      for (int j = i + 1; j < NCOPY; j++)
        if (c[j] == c[i]) cnt++;
      if (!r[8] && cnt > THRESH) r = {1'b1, c[i]};
    end
    return r;
  endfunction

  assign sz = nm_q * nr_q;

  always_comb begin
    case (phase)
      PH_MODES: lin = 32'(k);
      PH_REGS:  lin = NCOPY + 32'(k);
      PH_PLAIN: lin = 2*NCOPY + (32'(k) * 2) * 32'(sz) + 32'(idx);
      default:  lin = 2*NCOPY + (32'(k) * 2 + 1) * 32'(sz) + 32'(idx);
    endcase
  end

  assign in_rng   = lin < 32'(img_len);
  assign rd_en    = (state == ST_FETCH) && in_rng;
  assign rd_addr  = lin[AW-1:0];
  assign {maj_ok, maj_val} = vote(cpy);
  assign eval     = state == ST_EVAL;
  assign last     = idx == sz - 16'd1;
  assign busy     = state != ST_IDLE;
  assign nmodes   = nm_q;
  assign nregs    = nr_q;
  assign tbl_we   = eval && phase[1] && maj_ok;
  assign tbl_idx  = idx;
  assign tbl_data = (phase == PH_INV) ? ~maj_val : maj_val;
  assign done     = (tbl_we && last) ||
                    (eval && phase == PH_REGS && maj_ok && (maj_val == 8'd0 || nm_q == 8'd0));
  assign err      = (state == ST_FETCH && !in_rng) ||
                    (eval && !maj_ok && phase != PH_PLAIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      kq    <= '0;
      for (int i = 0; i < NCOPY; i++) cpy[i] <= '0;
    end else begin
      vld_q <= rd_en;
      kq    <= k;
      if (vld_q) cpy[kq] <= rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phase <= PH_MODES;
      k     <= '0;
      idx   <= '0;
      nm_q  <= '0;
      nr_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_FETCH;
          phase <= PH_MODES;
          k     <= '0;
          idx   <= '0;
          nm_q  <= '0;
          nr_q  <= '0;
        end
        ST_FETCH:
          if (!in_rng)                         state <= ST_IDLE;
          else if (k == KW'(NCOPY - 1))        state <= ST_DRAIN;
          else                                 k <= k + 1'b1;
        ST_DRAIN: state <= ST_EVAL;
        default: begin
          k     <= '0;
          state <= ST_FETCH;
          case (phase)
            PH_MODES:
              if (maj_ok) begin
                nm_q  <= maj_val;
                phase <= PH_REGS;
              end else state <= ST_IDLE;
            PH_REGS:
              if (maj_ok) begin
                nr_q <= maj_val;
                if (maj_val == 8'd0 || nm_q == 8'd0) state <= ST_IDLE;
                else phase <= PH_PLAIN;
              end else state <= ST_IDLE;
            PH_PLAIN:
              if (!maj_ok)   phase <= PH_INV;
              else if (last) state <= ST_IDLE;
              else           idx <= idx + 16'd1;
            default:
              if (!maj_ok)   state <= ST_IDLE;
              else if (last) state <= ST_IDLE;
              else begin
                idx   <= idx + 16'd1;
                phase <= PH_PLAIN;
              end
          endcase
        end
      endcase
    end
  end

  p_end_excl_r11: assert property (@(posedge clk) disable iff (!rst_n) !(done && err));
  p_rise_start_r2: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n) err |=> !busy);
  p_rd_range_r9: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> ({1'b0, rd_addr} < img_len));
  p_we_busy_r5: assert property (@(posedge clk) disable iff (!rst_n) tbl_we |-> busy && !err);
endmodule

// File: tb/majority_table_decoder_tb.sv
`timescale 1ns/1ps
module majority_table_decoder_tb;
  localparam int AW = 12;
  localparam int MAXC = 4096;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW:0] img_len = '0;
  logic rd_en, tbl_we, done, err, busy;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data, tbl_data, nmodes, nregs;
  logic [15:0] tbl_idx;
  logic [7:0] mem [1<<AW];

  int n_cmp = 0, n_bad = 0;
  bit e_we [MAXC];
  int e_idx [MAXC];
  int e_dat [MAXC];
  bit e_done [MAXC];
  bit e_err [MAXC];
  int endc, x_nm, x_nr;

  always #10 clk = ~clk;

  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  majority_table_decoder #(.AW(AW), .NCOPY(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
    .done(done), .err(err), .busy(busy), .nmodes(nmodes), .nregs(nregs)
  );

  task automatic chk(string tag, string what, int cyc, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic build(int nm, int nr, int seed, int short_by);
    int s, v;
    for (int a = 0; a < (1<<AW); a++) mem[a] = 8'((a * 37) ^ 8'h5A);
    s = nm * nr;
    for (int k = 0; k < 8; k++) begin
      mem[k] = 8'(nm);
      mem[8 + k] = 8'(nr);
    end
    for (int e = 0; e < s; e++) begin
      v = (e * 29 + seed) & 255;
      for (int k = 0; k < 8; k++) begin
        mem[16 + 2*k*s + e] = 8'(v);
        mem[16 + (2*k+1)*s + e] = ~8'(v);
      end
    end
    img_len = (AW+1)'(16 + 16*s - short_by);
  endtask

  task automatic mvote(int t, int a[8], output int st, output logic [7:0] v);
    logic [7:0] c [8];
    int n;
    v = 0;
    for (int k = 0; k < 8; k++) begin
      if (a[k] >= int'(img_len)) begin
        e_err[t+k] = 1; endc = t + k; st = 2; return;
      end
      c[k] = mem[a[k]];
    end
    for (int i = 0; i < 4; i++) begin
      n = 0;
      for (int j = i + 1; j < 8; j++) if (c[j] == c[i]) n++;
      if (n > 4) begin v = c[i]; st = 0; return; end
    end
    st = 1;
  endtask

  task automatic model();
    int t, st, s;
    int a[8];
    logic [7:0] v;
    for (int c = 0; c < MAXC; c++) begin
      e_we[c] = 0; e_idx[c] = 0; e_dat[c] = 0; e_done[c] = 0; e_err[c] = 0;
    end
    endc = 0; x_nm = 0; x_nr = 0; t = 1;
    for (int k = 0; k < 8; k++) a[k] = k;
    mvote(t, a, st, v);
    if (st == 2) return;
    if (st == 1) begin e_err[t+9] = 1; endc = t + 9; return; end
    x_nm = v; t += 10;
    for (int k = 0; k < 8; k++) a[k] = 8 + k;
    mvote(t, a, st, v);
    if (st == 2) return;
    if (st == 1) begin e_err[t+9] = 1; endc = t + 9; return; end
    x_nr = v;
    s = x_nm * x_nr;
    if (s == 0) begin e_done[t+9] = 1; endc = t + 9; return; end
    t += 10;
    for (int e = 0; e < s; e++) begin
      for (int k = 0; k < 8; k++) a[k] = 16 + 2*k*s + e;
      mvote(t, a, st, v);
      if (st == 2) return;
      if (st == 1) begin
        t += 10;
        for (int k = 0; k < 8; k++) a[k] = 16 + (2*k+1)*s + e;
        mvote(t, a, st, v);
        if (st == 2) return;
        if (st == 1) begin e_err[t+9] = 1; endc = t + 9; return; end
        v = ~v;
      end
      e_we[t+9] = 1; e_idx[t+9] = e; e_dat[t+9] = int'(v);
      if (e == s - 1) begin e_done[t+9] = 1; endc = t + 9; end
      t += 10;
    end
  endtask

  task automatic run_case(string tag, int inj);
    model();
    @(negedge clk);
    start = 1'b1;
    for (int cyc = 1; cyc <= endc + 2; cyc++) begin
      @(negedge clk);
      start = (cyc == inj);
      chk(tag, "tbl_we", cyc, int'(tbl_we), int'(e_we[cyc]));
      if (e_we[cyc]) begin
        chk(tag, "tbl_idx", cyc, int'(tbl_idx), e_idx[cyc]);
        chk(tag, "tbl_data", cyc, int'(tbl_data), e_dat[cyc]);
      end
      chk(tag, "done", cyc, int'(done), int'(e_done[cyc]));
      chk(tag, "err", cyc, int'(err), int'(e_err[cyc]));
    end
    start = 1'b0;
    chk(tag, "busy_end", endc + 2, int'(busy), 0);
    chk("R3", "nmodes", endc + 2, int'(nmodes), x_nm);
    chk("R3", "nregs", endc + 2, int'(nregs), x_nr);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    build(1, 1, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", 0, int'(busy), 0);
    chk("R1", "tbl_we", 0, int'(tbl_we), 0);
    chk("R1", "done", 0, int'(done), 0);
    chk("R1", "err", 0, int'(err), 0);
    chk("R1", "rd_en", 0, int'(rd_en), 0);
    chk("R1", "nmodes", 0, int'(nmodes), 0);

    // R2 R3 R5: clean image, table written in order
    build(3, 4, 1, 0);
    run_case("R5", 0);

    // R4: six equal copies pass, five fail and fall back
    build(2, 3, 5, 0);
    mem[0] = 8'h91; mem[1] = 8'h92;
    mem[16 + 0*6 + 1] = 8'h11; mem[16 + 2*6 + 1] = 8'h12;
    mem[16 + 2*6 + 2] = 8'h21; mem[16 + 4*6 + 2] = 8'h22;
    mem[16 + 0*6 + 4] = 8'h31; mem[16 + 2*6 + 4] = 8'h32; mem[16 + 4*6 + 4] = 8'h33;
    run_case("R4", 0);

    // R6: inverted fallback, including on the final entry
    build(2, 2, 9, 0);
    for (int k = 0; k < 3; k++) mem[16 + 2*k*4 + 0] = 8'hC3;
    for (int k = 0; k < 4; k++) mem[16 + 2*k*4 + 3] = 8'(8'h40 + k);
    run_case("R6", 0);

    // R7: plain and inverted votes both fail
    build(2, 2, 3, 0);
    for (int k = 0; k < 4; k++) begin
      mem[16 + 2*k*4 + 2] = 8'(8'h50 + k);
      mem[16 + (2*k+1)*4 + 2] = 8'(8'h60 + k);
    end
    run_case("R7", 0);

    // R8: count votes fail
    build(3, 3, 2, 0);
    mem[0] = 8'hA0; mem[1] = 8'hA1; mem[2] = 8'hA2;
    run_case("R8", 0);
    build(3, 3, 2, 0);
    mem[8] = 8'hB0; mem[9] = 8'hB1; mem[10] = 8'hB2;
    run_case("R8", 0);

    // R9: image too short for the copies or for the counts
    build(3, 4, 1, 8*12);
    run_case("R9", 0);
    build(3, 4, 1, 0);
    img_len = (AW+1)'(10);
    run_case("R9", 0);

    // R10: a zero count yields an empty table
    build(0, 5, 1, 0);
    img_len = (AW+1)'(64);
    run_case("R10", 0);
    build(4, 0, 1, 0);
    img_len = (AW+1)'(64);
    run_case("R10", 0);

    // R11: restart request while busy is ignored
    build(3, 4, 7, 0);
    run_case("R11", 35);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule